// File: doc/BRIEF.md
# Device Interrupt Status Controller

This block gathers four device event pulses into a sticky pending register and turns them into a single interrupt line. Software clears pending bits by writing ones to them, so writing back the value it just read acknowledges exactly the events it saw. Each source has its own enable bit, and a global enable bit gates the line as a whole. Pending bits latch whether or not their source is enabled. The enables only decide whether a pending bit drives the line.

The line's trigger style is fixed by the `IRQ_MODE` parameter: active-high level (the default), active-low level, a rising-edge pulse or a falling-edge pulse. A read-only capability word reports the chosen style, the four supported sources and whether the transfer burst size is static. The block also holds a writable interrupt-vector byte that software may probe and program. Register accesses use a simple write strobe and a combinational read port addressed by the offset within the register page.

Top module: `isc_irq_ctrl`

## Requirements
- R1: After reset the pending, enable and vector registers read zero, and in the default mode `irq_o` is low.
- R2: A one-cycle pulse on `evt_i[k]` sets a pending bit whether or not that source is enabled. The bit can be read at offset 0x010 after the next clock edge. `evt_i[0]` (data available) maps to bit 0, `evt_i[1]` (status valid) to bit 1, `evt_i[2]` (locality change) to bit 2 and `evt_i[3]` (command ready) to bit 7.
- R3: A write to offset 0x010 clears each pending bit written as 1. Pending bits written as 0 keep their value.
- R4: If a clearing write and a new event for the same bit fall in the same cycle, that bit stays set.
- R5: In the default active-high level mode, `irq_o` is high one clock after this condition holds: enable bit 31 (global) is 1 and at least one pending bit has its enable bit set. In every other case `irq_o` is low.
- R6: The enable register at offset 0x008 stores only bits 0, 1, 2, 7 and 31. All other bits read back as zero.
- R7: The vector register at offset 0x00C stores the low 8 bits written to it and reads them back zero-extended. Every value from 3 to 15 round-trips.
- R8: The capability word at offset 0x014 has bits 0, 1, 2 and 7 set. Of bits 3 to 6 it sets only bit 3+`IRQ_MODE` (3 level-high, 4 level-low, 5 rising, 6 falling). Bit 8 equals `BURST_STATIC`, and every other bit is zero.
- R9: A write to offset 0x014 has no effect on the capability word.
- R10: A read at any unmapped offset returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 4 | Event pulses: [0] data available, [1] status valid, [2] locality change, [3] command ready |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Offset within the register page |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| irq_o | output | 1 | Interrupt line, style set by `IRQ_MODE` |

## Verification
The hardest case to reach from the ports is a clear and a new event landing on the same pending bit in the same cycle. The bench reaches it by driving the event pulse and the clearing write on the same falling edge, so both are seen at one rising edge. It then reads the bit back. Around this, the bench sweeps every combination of event subset, per-source enable subset and global enable, and checks both the pending word and the line against values it derives arithmetically.

// File: rtl/isc_pkg.sv
package isc_pkg;
   localparam int NSRC     = 4;
   localparam int GLB_BIT  = 31;
   localparam int SRC_POS [NSRC] = '{0, 1, 2, 7};

   localparam logic [11:0] OFS_ENABLE = 12'h008;
   localparam logic [11:0] OFS_VECTOR = 12'h00C;
   localparam logic [11:0] OFS_STATUS = 12'h010;
   localparam logic [11:0] OFS_CAPS   = 12'h014;

   localparam int MODE_LEVEL_HIGH = 0;
   localparam int MODE_LEVEL_LOW  = 1;
   localparam int MODE_RISE       = 2;
   localparam int MODE_FALL       = 3;

   // capability word: source-support mirror, one trigger-style flag, burst flag
   function automatic logic [31:0] caps_word(input int mode, input int burst_static);
      logic [31:0] w;
      w = '0;
      for (int i = 0; i < NSRC; i++) w[SRC_POS[i]] = 1'b1;
      w[3 + mode] = 1'b1;
      w[8] = (burst_static != 0);
      return w;
   endfunction
endpackage

// File: rtl/isc_event_latch.sv
module isc_event_latch #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] evt_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] pend_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) pend_o <= '0;
      else        pend_o <= (pend_o & ~clr_i) | evt_i;
   end

   a_r2_event_latches: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i != '0) |=> ((pend_o & $past(evt_i)) == $past(evt_i)));

   a_r3_clear_without_event: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr_i & ~evt_i) != '0) |=> ((pend_o & $past(clr_i & ~evt_i)) == '0));
endmodule

// File: rtl/isc_irq_out.sv
module isc_irq_out #(
   parameter int MODE = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_i,
   output logic irq_o
);
   logic req_d;

   always_ff @(posedge clk) begin
      if (!rst_n) req_d <= 1'b0;
      else        req_d <= req_i;
   end

   generate
      if (MODE == 0) begin : g_lvl_hi
         always_ff @(posedge clk) begin
            if (!rst_n) irq_o <= 1'b0;
            else        irq_o <= req_i;
         end
      end else if (MODE == 1) begin : g_lvl_lo
         always_ff @(posedge clk) begin
            if (!rst_n) irq_o <= 1'b1;
            else        irq_o <= ~req_i;
         end
      end else if (MODE == 2) begin : g_rise
         always_ff @(posedge clk) begin
            if (!rst_n) irq_o <= 1'b0;
            else        irq_o <= req_i & ~req_d;
         end
      end else begin : g_fall
         always_ff @(posedge clk) begin
            if (!rst_n) irq_o <= 1'b1;
            else        irq_o <= ~(req_i & ~req_d);
         end
      end
   endgenerate
endmodule

// File: rtl/isc_irq_ctrl.sv
module isc_irq_ctrl
   import isc_pkg::*;
#(
   parameter int ADDR_W       = 12,
   parameter int VEC_W        = 8,
   parameter int IRQ_MODE     = MODE_LEVEL_HIGH,
   parameter int BURST_STATIC = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   evt_i,
   input  logic              reg_wr_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic [31:0]       reg_wdata_i,
   output logic [31:0]       reg_rdata_o,
   output logic              irq_o
);
   localparam logic [31:0] CAPS = caps_word(IRQ_MODE, BURST_STATIC);
   localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(OFS_ENABLE);
   localparam logic [ADDR_W-1:0] A_VEC = ADDR_W'(OFS_VECTOR);
   localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(OFS_STATUS);
   localparam logic [ADDR_W-1:0] A_CAP = ADDR_W'(OFS_CAPS);

   generate
      if (IRQ_MODE < 0 || IRQ_MODE > 3) begin : g_bad_mode
         $error("IRQ_MODE must be 0..3");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("ADDR_W too small for register page");
      end
      if (VEC_W < 4 || VEC_W > 8) begin : g_bad_vec
         $error("VEC_W must be 4..8");
      end
   endgenerate

   logic            wr_en_reg, wr_vec, wr_sts;
   logic [NSRC-1:0] en_src, clr_v, pend;
   logic            en_glb;
   logic [VEC_W-1:0] vec_q;
   logic            req;
   logic            unused_wdata;

   assign wr_en_reg = reg_wr_i && (reg_addr_i == A_EN);
   assign wr_vec    = reg_wr_i && (reg_addr_i == A_VEC);
   assign wr_sts    = reg_wr_i && (reg_addr_i == A_STS);
   assign unused_wdata = ^reg_wdata_i;

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      assign clr_v[i] = wr_sts & reg_wdata_i[SRC_POS[i]];
      always_ff @(posedge clk) begin
         if (!rst_n)         en_src[i] <= 1'b0;
         else if (wr_en_reg) en_src[i] <= reg_wdata_i[SRC_POS[i]];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_glb <= 1'b0;
         vec_q  <= '0;
      end else begin
         if (wr_en_reg) en_glb <= reg_wdata_i[GLB_BIT];
         if (wr_vec)    vec_q  <= reg_wdata_i[VEC_W-1:0];
      end
   end

   isc_event_latch #(.N(NSRC)) u_latch (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .clr_i(clr_v), .pend_o(pend)
   );

   assign req = en_glb & |(pend & en_src);

   isc_irq_out #(.MODE(IRQ_MODE)) u_out (
      .clk(clk), .rst_n(rst_n), .req_i(req), .irq_o(irq_o)
   );

   always_comb begin
      reg_rdata_o = '0;
      if (reg_addr_i == A_EN) begin
         for (int i = 0; i < NSRC; i++) reg_rdata_o[SRC_POS[i]] = en_src[i];
         reg_rdata_o[GLB_BIT] = en_glb;
      end else if (reg_addr_i == A_STS) begin
         for (int i = 0; i < NSRC; i++) reg_rdata_o[SRC_POS[i]] = pend[i];
      end else if (reg_addr_i == A_VEC) begin
         reg_rdata_o[VEC_W-1:0] = vec_q;
      end else if (reg_addr_i == A_CAP) begin
         reg_rdata_o = CAPS;
      end
   end

   generate
      if (IRQ_MODE == MODE_LEVEL_HIGH) begin : g_chk_lvl
         a_r5_line_tracks_request: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (irq_o == $past(en_glb & |(pend & en_src))));
         a_r5_global_gates_line: assert property (@(posedge clk) disable iff (!rst_n)
            !en_glb |=> !irq_o);
      end
   endgenerate

   a_r4_event_wins_clear: assert property (@(posedge clk) disable iff (!rst_n)
      ((evt_i & clr_v) != '0) |=> ((pend & $past(evt_i & clr_v)) == $past(evt_i & clr_v)));
endmodule

// File: tb/tb_isc_irq_ctrl.sv
module tb_isc_irq_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  evt = '0;
   logic        wr = 1'b0;
   logic [11:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;
   int          n_run = 0;
   int          n_fail = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   isc_irq_ctrl dut (
      .clk(clk), .rst_n(rst_n), .evt_i(evt), .reg_wr_i(wr),
      .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
   );

   function automatic logic [31:0] spread(input logic [3:0] v);
      return {24'd0, v[3], 4'd0, v[2:0]};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk); wr = 1'b1; addr = a; wdata = d;
      @(negedge clk); wr = 1'b0; wdata = '0;
   endtask

   task automatic rd_reg(input logic [11:0] a, output logic [31:0] d);
      addr = a; #1; d = rdata;
   endtask

   task automatic pulse(input logic [3:0] e);
      @(negedge clk); evt = e;
      @(negedge clk); evt = '0;
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_fail++; n_run++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      rd_reg(12'h010, d); check("R1 status", d, 0);
      rd_reg(12'h008, d); check("R1 enable", d, 0);
      rd_reg(12'h00C, d); check("R1 vector", d, 0);
      check("R1 irq", {31'd0, irq}, 0);

      // R2/R5 sweep: events x enables x global
      for (int g = 0; g < 2; g++) begin
         for (int en = 0; en < 16; en++) begin
            for (int ev = 0; ev < 16; ev++) begin
               wr_reg(12'h008, (g ? 32'h8000_0000 : 0) | spread(4'(en)));
               wr_reg(12'h010, 32'hFFFF_FFFF);
               pulse(4'(ev));
               rd_reg(12'h010, d); check("R2 latch", d, spread(4'(ev)));
               @(negedge clk); #1;
               check("R5 irq level", {31'd0, irq},
                     {31'd0, (g == 1) && ((ev & en) != 0)});
            end
         end
      end

      // R3 partial clear
      for (int s = 0; s < 16; s++) begin
         wr_reg(12'h008, 0);
         pulse(4'hF);
         wr_reg(12'h010, spread(4'(s)) | 32'h0000_FF78);
         rd_reg(12'h010, d); check("R3 w1c", d, spread(~4'(s)));
      end

      // R4 event and clear collide on bit 0, clear also hits bit 7
      wr_reg(12'h010, 32'hFFFF_FFFF);
      pulse(4'b1001);
      @(negedge clk); wr = 1'b1; addr = 12'h010; wdata = 32'h81; evt = 4'b0001;
      @(negedge clk); wr = 1'b0; wdata = '0; evt = '0;
      rd_reg(12'h010, d); check("R4 collide", d, 32'h1);

      // R6 reserved enable bits
      wr_reg(12'h008, 32'hFFFF_FFFF);
      rd_reg(12'h008, d); check("R6 enable mask", d, 32'h8000_0087);
      wr_reg(12'h008, 32'h7FFF_FF78);
      rd_reg(12'h008, d); check("R6 enable mask zero", d, 0);

      // R7 vector probe range
      for (int v = 3; v < 16; v++) begin
         wr_reg(12'h00C, 32'hABCD_0000 | v);
         rd_reg(12'h00C, d); check("R7 vector", d, v);
      end
      wr_reg(12'h00C, 32'h0000_01A5);
      rd_reg(12'h00C, d); check("R7 vector byte", d, 32'hA5);

      // R8 capability word, R9 write ignored
      rd_reg(12'h014, d); check("R8 caps", d, 32'h0000_018F);
      wr_reg(12'h014, 32'h0);
      rd_reg(12'h014, d); check("R9 caps ro", d, 32'h0000_018F);

      // R10 unmapped offsets
      for (int a = 0; a < 64; a += 4) begin
         if (a != 8 && a != 12 && a != 16 && a != 20) begin
            rd_reg(12'(a), d); check("R10 unmapped", d, 0);
         end
      end
      rd_reg(12'hF00, d); check("R10 unmapped high", d, 0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule